// File: doc/BRIEF.md
# MSI Ring Buffer Controller

This block takes message-signalled interrupt events, each carrying a 16-bit vector, and stores every one as a 16-byte record in a circular buffer in host memory. Each record is sent as a single 128-bit memory write request over a valid/ready handshake. The write goes to the programmed buffer base plus the current write offset. Once the write completes, the write offset moves forward by one record and wraps at the programmed ring size.

Software sets up the block through a small word-addressed register bus. It writes the control word, the two halves of the base address and the read offset. It reads the write offset, which only the hardware changes. A level interrupt reports that unread records exist. The block can optionally detect a full ring. On a full ring it either drops new events or overwrites the next slot, and in both cases it records the overflow in a sticky flag.

Top module: `msi_ring_ctrl`

## Requirements
- R1: Registers sit at word addresses 0x0 (control), 0x3 (base bits 63:32), 0x4 (base bits 31:0), 0x5 (read offset) and 0x6 (write offset). Unmapped addresses read as zero. After reset every register reads zero, `irq` and `mem_valid` are low and `msi_ready` is high.
- R2: Control bit 0 is capture enable, bit 1 is full-check enable, bit 3 is interrupt enable, bit 4 is stop-when-full, bits 9:8 are the size code and bit 31 is the overflow flag. All of these read back at the same positions.
- R3: Size code n selects a ring of 2^(15+n) bytes (32 KB to 256 KB). Offsets written through address 0x5 are masked to that size and to 16-byte alignment.
- R4: A record's address is base plus the write offset. Its data uses little-endian byte lanes, with byte k at data bits 8k+7:8k. Bytes 0 and 1 hold the low and high bytes of the vector, and bytes 2 to 15 are zero.
- R5: An event is taken when `msi_valid` and `msi_ready` are high on the same clock edge. `msi_ready` is low while a record is pending. A pending record keeps `mem_valid`, `mem_addr` and `mem_data` unchanged until the edge on which `mem_ready` is high, and `mem_valid` is low after that edge.
- R6: On each completed memory handshake the write offset grows by 16 modulo the ring size. It changes at no other time except the reset described in R11.
- R7: With capture enable clear, incoming events are accepted and discarded. No memory write is issued and the write offset stays unchanged.
- R8: With full-check enabled, the ring is full when (write offset + 16) mod size equals the read offset. If an event arrives on a full ring with stop-when-full set, it is dropped. With stop-when-full clear, the event is written anyway. In both cases the overflow flag is set. With full-check disabled, the block never detects a full ring.
- R9: The overflow flag stays set until software writes the control word with bit 31 high.
- R10: `irq` is high exactly when interrupt enable is set and the read offset differs from the write offset.
- R11: Writing either base word, or writing control with a size code different from the current one, clears both offsets. Writes to address 0x6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| msi_valid | input | 1 | Inbound event present |
| msi_vector | input | 16 | Interrupt vector of the event |
| msi_ready | output | 1 | Block can take an event |
| mem_valid | output | 1 | Memory write request pending |
| mem_ready | input | 1 | Memory side accepts the request |
| mem_addr | output | 64 | Byte address of the record |
| mem_data | output | 128 | Record contents, little-endian byte lanes |
| irq | output | 1 | Level interrupt to the host |

## Verification
A wrong write offset shows in two places. It appears in the address of the next record, and it appears in the value read back at address 0x6 as soon as the handshake that moved it has completed. A wrong full decision appears on the same edge the event is accepted. Either `mem_valid` fails to rise, or it rises when it should not, and the overflow bit reads wrong on the next register read. Offset state that disagrees with software is seen on `irq` within one cycle of the change. The bench therefore checks every record and the register state after each event, and it runs past a full wrap of the smallest ring.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;
  localparam int REG_AW      = 3;
  localparam int REG_DW      = 32;
  localparam int VEC_W       = 16;
  localparam int ENTRY_W     = 128;
  localparam int ADDR_W      = 64;
  localparam int SZ_W        = 2;
  localparam int MIN_SHIFT   = 15;
  localparam int ENTRY_BYTES = ENTRY_W / 8;
  localparam int OFF_W       = MIN_SHIFT + (1 << SZ_W) - 1;

  localparam logic [REG_AW-1:0] A_CTRL    = 3'd0;
  localparam logic [REG_AW-1:0] A_BASE_HI = 3'd3;
  localparam logic [REG_AW-1:0] A_BASE_LO = 3'd4;
  localparam logic [REG_AW-1:0] A_RDOFF   = 3'd5;
  localparam logic [REG_AW-1:0] A_WROFF   = 3'd6;

  localparam int B_EN     = 0;
  localparam int B_FCHK   = 1;
  localparam int B_IRQ    = 3;
  localparam int B_STOP   = 4;
  localparam int B_SZ     = 8;
  localparam int B_OVF    = 31;

  typedef struct packed {
    logic              en;
    logic              full_chk;
    logic              irq_en;
    logic              stop;
    logic [SZ_W-1:0]   sz;
    logic [ADDR_W-1:0] base;
  } cfg_t;

  // Mask keeping an offset inside the ring and aligned to one record.
  function automatic logic [OFF_W-1:0] off_mask(input logic [SZ_W-1:0] sz);
    logic [OFF_W:0] span;
    span = (OFF_W+1)'(1) << (MIN_SHIFT + 32'(sz));
    return (span[OFF_W-1:0] - OFF_W'(1)) & ~OFF_W'(ENTRY_BYTES - 1);
  endfunction

  function automatic logic [OFF_W-1:0] next_off(input logic [OFF_W-1:0] off,
                                                input logic [SZ_W-1:0]  sz);
    return (off + OFF_W'(ENTRY_BYTES)) & off_mask(sz);
  endfunction

  function automatic logic ring_full(input logic [OFF_W-1:0] wr,
                                     input logic [OFF_W-1:0] rd,
                                     input logic [SZ_W-1:0]  sz);
    return next_off(wr, sz) == rd;
  endfunction

  // Little-endian byte lanes: vector low byte in lane 0, high byte in lane 1.
  function automatic logic [ENTRY_W-1:0] format_entry(input logic [VEC_W-1:0] vec);
    logic [ENTRY_W-1:0] e;
    e = '0;
    e[7:0]  = vec[7:0];
    e[15:8] = vec[15:8];
    return e;
  endfunction
endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
  import msi_ring_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              adv,
  input  logic              ovf_set,
  output cfg_t              cfg,
  output logic [OFF_W-1:0]  wr_off,
  output logic [OFF_W-1:0]  rd_off,
  output logic              ovf,
  output logic              cfg_rst
);
  logic ctrl_we;

  always_comb begin
    ctrl_we = reg_we && (reg_addr == A_CTRL);
    cfg_rst = reg_we && ((reg_addr == A_BASE_HI) || (reg_addr == A_BASE_LO) ||
              (ctrl_we && (reg_wdata[B_SZ +: SZ_W] != cfg.sz)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg    <= '0;
      wr_off <= '0;
      rd_off <= '0;
      ovf    <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_CTRL: begin
            cfg.en       <= reg_wdata[B_EN];
            cfg.full_chk <= reg_wdata[B_FCHK];
            cfg.irq_en   <= reg_wdata[B_IRQ];
            cfg.stop     <= reg_wdata[B_STOP];
            cfg.sz       <= reg_wdata[B_SZ +: SZ_W];
          end
          A_BASE_HI: cfg.base[ADDR_W-1:REG_DW] <= reg_wdata;
          A_BASE_LO: cfg.base[REG_DW-1:0]      <= reg_wdata;
          default: ;
        endcase
      end
      if (cfg_rst)
        rd_off <= '0;
      else if (reg_we && (reg_addr == A_RDOFF))
        rd_off <= reg_wdata[OFF_W-1:0] & off_mask(cfg.sz);
      if (cfg_rst)
        wr_off <= '0;
      else if (adv)
        wr_off <= next_off(wr_off, cfg.sz);
      if (ovf_set)
        ovf <= 1'b1;
      else if (ctrl_we && reg_wdata[B_OVF])
        ovf <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_EN]          = cfg.en;
        reg_rdata[B_FCHK]        = cfg.full_chk;
        reg_rdata[B_IRQ]         = cfg.irq_en;
        reg_rdata[B_STOP]        = cfg.stop;
        reg_rdata[B_SZ +: SZ_W]  = cfg.sz;
        reg_rdata[B_OVF]         = ovf;
      end
      A_BASE_HI: reg_rdata = cfg.base[ADDR_W-1:REG_DW];
      A_BASE_LO: reg_rdata = cfg.base[REG_DW-1:0];
      A_RDOFF:   reg_rdata = REG_DW'(rd_off);
      A_WROFF:   reg_rdata = REG_DW'(wr_off);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
  import msi_ring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               full_chk,
  input  logic               stop,
  input  logic [SZ_W-1:0]    sz,
  input  logic [ADDR_W-1:0]  base,
  input  logic [OFF_W-1:0]   wr_off,
  input  logic [OFF_W-1:0]   rd_off,
  input  logic               msi_valid,
  input  logic [VEC_W-1:0]   msi_vector,
  output logic               msi_ready,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_data,
  output logic               adv,
  output logic               ovf_set
);
  logic             pend;
  logic [VEC_W-1:0] vec_q;
  logic [ADDR_W-1:0] addr_q;
  logic accept, full_now, drop;

  always_comb begin
    msi_ready = !pend;
    accept    = msi_valid && !pend;
    full_now  = full_chk && ring_full(wr_off, rd_off, sz);
    drop      = !en || (full_now && stop);
    ovf_set   = accept && en && full_now;
    adv       = pend && mem_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      vec_q  <= '0;
      addr_q <= '0;
    end else begin
      if (adv)
        pend <= 1'b0;
      if (accept && !drop) begin
        pend   <= 1'b1;
        vec_q  <= msi_vector;
        addr_q <= base + ADDR_W'(wr_off);
      end
    end
  end

  assign mem_valid = pend;
  assign mem_addr  = addr_q;
  assign mem_data  = format_entry(vec_q);
endmodule

// File: rtl/msi_ring_ctrl.sv
module msi_ring_ctrl
  import msi_ring_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  input  logic               msi_valid,
  input  logic [VEC_W-1:0]   msi_vector,
  output logic               msi_ready,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [ENTRY_W-1:0] mem_data,
  output logic               irq
);
  cfg_t             cfg;
  logic [OFF_W-1:0] wr_off, rd_off;
  logic             adv, ovf_set, ovf, cfg_rst;

  msi_ring_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adv(adv), .ovf_set(ovf_set),
    .cfg(cfg), .wr_off(wr_off), .rd_off(rd_off), .ovf(ovf), .cfg_rst(cfg_rst)
  );

  msi_ring_writer u_writer (
    .clk(clk), .rst_n(rst_n),
    .en(cfg.en), .full_chk(cfg.full_chk), .stop(cfg.stop), .sz(cfg.sz), .base(cfg.base),
    .wr_off(wr_off), .rd_off(rd_off),
    .msi_valid(msi_valid), .msi_vector(msi_vector), .msi_ready(msi_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .adv(adv), .ovf_set(ovf_set)
  );

  assign irq = cfg.irq_en && (rd_off != wr_off);
endmodule

// File: rtl/msi_ring_chk.sv
module msi_ring_chk
  import msi_ring_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [ENTRY_W-1:0] mem_data,
  input logic               irq,
  input logic [OFF_W-1:0]   wr_off,
  input logic [OFF_W-1:0]   rd_off,
  input logic               adv,
  input logic               cfg_rst,
  input logic               ovf,
  input logic               ovf_set
);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

  assert_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> !mem_valid);

  assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_off[3:0] == 4'd0) && (rd_off[3:0] == 4'd0));

  assert_wr_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv && !cfg_rst |=> $stable(wr_off));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(ovf_set));

  assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rst |=> !irq);
endmodule

bind msi_ring_ctrl msi_ring_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
  .wr_off(wr_off), .rd_off(rd_off), .adv(adv), .cfg_rst(cfg_rst),
  .ovf(ovf), .ovf_set(ovf_set)
);

// File: tb/tb_msi_ring_ctrl.sv
module tb_msi_ring_ctrl;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         msi_valid = 1'b0;
  logic [15:0]  msi_vector = '0;
  logic         msi_ready;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [63:0]  mem_addr;
  logic [127:0] mem_data;
  logic         irq;

  msi_ring_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msi_valid(msi_valid),
    .msi_vector(msi_vector), .msi_ready(msi_ready), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;

  bit m_en, m_fc, m_ie, m_stop, m_ovf;
  int m_sz, m_rd, m_wr;
  logic [63:0] m_base;

  function automatic int b_size(input int sz);
    return 32768 << sz;
  endfunction

  function automatic int b_next(input int off, input int sz);
    return (off + 16) % b_size(sz);
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_ctl(input bit en, input bit fc, input bit ie, input bit stop,
                         input int sz, input bit clr);
    logic [31:0] w;
    w = '0;
    w[0] = en; w[1] = fc; w[3] = ie; w[4] = stop; w[9:8] = 2'(sz); w[31] = clr;
    wr_reg(3'd0, w);
    if (sz != m_sz) begin m_rd = 0; m_wr = 0; end
    m_en = en; m_fc = fc; m_ie = ie; m_stop = stop; m_sz = sz;
    if (clr) m_ovf = 1'b0;
  endtask

  task automatic set_base(input logic [63:0] b);
    wr_reg(3'd3, b[63:32]);
    wr_reg(3'd4, b[31:0]);
    m_base = b; m_rd = 0; m_wr = 0;
  endtask

  task automatic set_rd(input int v);
    wr_reg(3'd5, 32'(v));
    m_rd = v & (b_size(m_sz) - 1) & ~15;
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    rd_reg(3'd6, d); chk({req, " R6 write offset"}, 128'(d), 128'(m_wr));
    rd_reg(3'd5, d); chk({req, " R11 read offset"}, 128'(d), 128'(m_rd));
    rd_reg(3'd0, d); chk({req, " R9 overflow bit"}, 128'(d[31]), 128'(m_ovf));
    chk({req, " R10 irq"}, 128'(irq), 128'(m_ie && (m_rd != m_wr)));
  endtask

  task automatic send(input logic [15:0] vec, input int delay, input string req);
    bit full, drop;
    logic [127:0] exp_d;
    logic [63:0]  exp_a;
    @(negedge clk);
    chk("R5 ready when idle", 128'(msi_ready), 128'(1));
    msi_valid = 1'b1; msi_vector = vec;
    @(negedge clk);
    msi_valid = 1'b0;
    full = m_fc && (b_next(m_wr, m_sz) == m_rd);
    drop = !m_en || (full && m_stop);
    if (m_en && full) m_ovf = 1'b1;
    chk({req, " mem_valid"}, 128'(mem_valid), 128'(!drop));
    if (!drop) begin
      exp_a = m_base + 64'(m_wr);
      exp_d = '0;
      exp_d[7:0] = vec[7:0];
      exp_d[15:8] = vec[15:8];
      chk("R4 address", 128'(mem_addr), 128'(exp_a));
      chk("R4 data", mem_data, exp_d);
      chk("R5 busy", 128'(msi_ready), 128'(0));
      for (int i = 0; i < delay; i++) begin
        @(negedge clk);
        chk("R5 hold valid", 128'(mem_valid), 128'(1));
        chk("R5 hold addr", 128'(mem_addr), 128'(exp_a));
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      m_wr = b_next(m_wr, m_sz);
      chk("R5 released", 128'(mem_valid), 128'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;
    void'($urandom(32'd20240607));
    m_en = 0; m_fc = 0; m_ie = 0; m_stop = 0; m_ovf = 0;
    m_sz = 0; m_rd = 0; m_wr = 0; m_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    foreach (d[i]) ;
    rd_reg(3'd0, d); chk("R1 reset ctrl", 128'(d), 128'(0));
    rd_reg(3'd3, d); chk("R1 reset base hi", 128'(d), 128'(0));
    rd_reg(3'd4, d); chk("R1 reset base lo", 128'(d), 128'(0));
    rd_reg(3'd5, d); chk("R1 reset rd", 128'(d), 128'(0));
    rd_reg(3'd6, d); chk("R1 reset wr", 128'(d), 128'(0));
    chk("R1 reset irq", 128'(irq), 128'(0));
    chk("R1 reset mem_valid", 128'(mem_valid), 128'(0));
    chk("R1 reset msi_ready", 128'(msi_ready), 128'(1));

    // R1 base readback, R2 control layout
    set_base(64'h0000_0012_3450_0000);
    rd_reg(3'd3, d); chk("R1 base hi", 128'(d), 128'(32'h12));
    rd_reg(3'd4, d); chk("R1 base lo", 128'(d), 128'(32'h3450_0000));
    rd_reg(3'd1, d); chk("R1 unmapped", 128'(d), 128'(0));
    set_ctl(1, 1, 1, 1, 0, 0);
    rd_reg(3'd0, d); chk("R2 control", 128'(d), 128'(32'h1B));

    // R4 format, R5 hold, R10 irq
    send(16'hBEEF, 0, "R4 first");
    send(16'h0001, 3, "R5 delayed");
    check_state("R10 pending");
    set_rd(m_wr);
    check_state("R10 caught up");
    set_rd(32'h12345);
    check_state("R3 rd mask");

    // R11 write offset read-only
    wr_reg(3'd6, 32'h100);
    check_state("R11 wr read-only");

    // R7 capture disabled
    set_ctl(0, 1, 1, 1, 0, 0);
    send(16'h7777, 0, "R7 disabled");
    check_state("R7 disabled");
    set_ctl(1, 1, 1, 1, 0, 0);

    // R8 full with stop, R9 sticky and clear
    set_rd(b_next(m_wr, m_sz));
    send(16'h0A0A, 0, "R8 full drop");
    check_state("R8 full drop");
    send(16'h0B0B, 0, "R9 still dropped");
    check_state("R9 sticky");
    set_ctl(1, 1, 1, 1, 0, 1);
    check_state("R9 cleared");

    // R8 overwrite mode
    set_ctl(1, 1, 1, 0, 0, 0);
    send(16'h0C0C, 1, "R8 overwrite");
    check_state("R8 overwrite");
    set_ctl(1, 1, 1, 0, 0, 1);

    // R8 full-check disabled
    set_ctl(1, 0, 1, 1, 0, 0);
    set_rd(b_next(m_wr, m_sz));
    send(16'h0D0D, 0, "R8 no check");
    check_state("R8 no check");

    // R3 / R11 size change
    set_ctl(1, 0, 1, 1, 2, 0);
    check_state("R11 size reset");
    rd_reg(3'd0, d); chk("R3 size code", 128'(d[9:8]), 128'(2));
    set_rd(32'h3FFF0);
    check_state("R3 128K mask");
    set_ctl(1, 0, 1, 1, 3, 0);
    set_rd(32'h3FFF0);
    check_state("R3 256K mask");
    set_rd(32'h80);
    set_base(64'hFFFF_0000_0000_0000);
    check_state("R11 base reset");

    // R6 full wrap of the 32 KB ring
    set_ctl(1, 0, 1, 0, 0, 0);
    k = b_size(0) / 16;
    for (int i = 0; i < k; i++) begin
      send(16'(i), 0, "R6 wrap");
      if ((i % 512) == 511) check_state("R6 wrap");
    end
    chk("R6 wrapped to zero", 128'(m_wr), 128'(0));

    // Random mix with full detection
    set_ctl(1, 1, 1, 1, 0, 1);
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 7) == 0)
        set_rd((m_wr + 16 * $urandom_range(0, 2)) % b_size(m_sz));
      if ($urandom_range(0, 15) == 0)
        set_ctl(1, 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 0,
                $urandom_range(0, 1) == 1);
      send(16'($urandom), $urandom_range(0, 3), "R8 random");
      check_state("R8 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule